// File: doc/BRIEF.md
# Receive Descriptor Ring Run Controller

This block sequences a receive DMA engine over a ring of descriptors kept in a small local descriptor memory. A software-controlled enable level starts and stops the engine. A base-address register gives the start of the ring. The engine reads each descriptor's ownership flag. If the DMA owns the descriptor, the engine hands it to the data path for the next incoming frame. When the frame is complete, the engine writes the descriptor back to the host and moves to the next entry in the ring.

If the engine finds a descriptor that the DMA does not own, it parks in a Suspended state and raises a sticky buffer-unavailable flag. A fresh frame arrival causes it to re-read the same descriptor. Stop requests are deferred until any frame in transfer has finished. The ring position survives a stop, so a restart continues where the engine left off. Moving the payload into the buffers is outside this block; it appears only as the frame-available and frame-done handshake.

Top module: `rxdesc_run_ctrl`

## Requirements
- R1: While `run_state` is Stopped (encoding 0), a high `run_en` moves the engine to Running (encoding 1) and issues a descriptor read (`desc_rd`) at `cur_ptr`.
- R2: A `base_wr` pulse while Stopped loads `base_addr` into both the ring base and `cur_ptr`. A restart after a stop issues its first read at the pointer saved when the engine stopped.
- R3: A descriptor read that returns `desc_own` = 0 moves the engine to Suspended (encoding 2) and sets `buf_unavail`.
- R4: A `frame_done` during transfer (`xfer_active`) produces one `desc_wb` strobe at the current descriptor address. The pointer then advances by `DESC_BYTES`, or returns to the ring base when that descriptor returned `desc_eor` = 1.
- R5: Lowering `run_en` during a transfer keeps the engine Running until `frame_done`. The engine then performs the write-back and enters Stopped with the advanced pointer.
- R6: Lowering `run_en` while Running and idle, or while Suspended, enters Stopped with no write-back and with `cur_ptr` unchanged.
- R7: In Suspended, a rising edge of `frame_avail` re-reads the descriptor at `cur_ptr`. If the DMA now owns it, the engine returns to Running.
- R8: After reset the engine is Stopped, `cur_ptr` is 0, `buf_unavail` is 0, and no strobe is active.
- R9: `buf_unavail` stays set until a `buf_unavail_clr` pulse clears it. A new set in the same cycle as a clear takes priority.
- R10: `base_wr` is ignored unless the engine is Stopped.
- R11: In Suspended with `run_en` held high and no new frame edge, no descriptor read is issued; a start level has no effect outside Stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Start (1) / stop (0) control level |
| base_wr | input | 1 | Write pulse for the ring base register |
| base_addr | input | ADDR_W | Ring base address value |
| frame_avail | input | 1 | Data path holds a frame waiting for a descriptor |
| frame_done | input | 1 | Pulse: current frame transfer has completed |
| desc_rd | output | 1 | Descriptor read strobe |
| desc_addr | output | ADDR_W | Address for descriptor read or write-back |
| desc_own | input | 1 | Ownership flag of the read descriptor (1 = DMA) |
| desc_eor | input | 1 | End-of-ring flag of the read descriptor |
| desc_wb | output | 1 | Descriptor write-back strobe (returns ownership to host) |
| xfer_active | output | 1 | Descriptor granted to the data path for a frame |
| cur_ptr | output | ADDR_W | Current descriptor pointer |
| run_state | output | 2 | 0 Stopped, 1 Running, 2 Suspended |
| buf_unavail | output | 1 | Sticky buffer-unavailable flag |
| buf_unavail_clr | input | 1 | Write-one-to-clear pulse for `buf_unavail` |

## Verification
The bench runs the ring through several patterns. A full lap of owned descriptors shows the step-versus-wrap pointer behaviour and the write-back order. Running out of owned descriptors separates suspension from normal idling. Granting ownership again before a frame edge shows that a re-poll happens only on an arrival. Stop requests are issued in three positions: idle Running, Suspended, and mid-transfer. Comparing these shows which requests act at once and which wait for the frame to finish, and checking the restart read addresses confirms the ring position survived.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

   typedef enum logic [2:0] {
      F_STOP  = 3'd0,
      F_FETCH = 3'd1,
      F_RSP   = 3'd2,
      F_IDLE  = 3'd3,
      F_XFER  = 3'd4,
      F_WB    = 3'd5,
      F_SUSP  = 3'd6
   } fsm_t;

   localparam logic [1:0] RS_STOPPED   = 2'd0;
   localparam logic [1:0] RS_RUNNING   = 2'd1;
   localparam logic [1:0] RS_SUSPENDED = 2'd2;

   function automatic logic [1:0] fsm_to_run_state(input fsm_t s);
      case (s)
         F_STOP:  return RS_STOPPED;
         F_SUSP:  return RS_SUSPENDED;
         default: return RS_RUNNING;
      endcase
   endfunction

endpackage

// File: rtl/rxd_read_tracker.sv
module rxd_read_tracker #(
   parameter int RD_LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   output logic rsp_valid
);

   generate
      if (RD_LAT == 1) begin : g_single
         logic v_q;
         always_ff @(posedge clk) begin
            if (!rst_n) v_q <= 1'b0;
            else        v_q <= issue;
         end
         assign rsp_valid = v_q;
      end else begin : g_pipe
         logic [RD_LAT-1:0] v_sr;
         always_ff @(posedge clk) begin
            if (!rst_n) v_sr <= '0;
            else        v_sr <= {v_sr[RD_LAT-2:0], issue};
         end
         assign rsp_valid = v_sr[RD_LAT-1];
      end
   endgenerate

endmodule

// File: rtl/rxd_ptr_unit.sv
module rxd_ptr_unit #(
   parameter int ADDR_W     = 16,
   parameter int DESC_BYTES = 16,
   parameter bit USE_EOR    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              accept,
   input  logic              eor_in,
   input  logic              advance,
   output logic [ADDR_W-1:0] cur_ptr,
   output logic [ADDR_W-1:0] base_ptr
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] nxt_ptr;

   generate
      if (USE_EOR) begin : g_ring_flag
         logic eor_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      eor_q <= 1'b0;
            else if (accept) eor_q <= eor_in;
         end
         assign nxt_ptr = eor_q ? base_q : cur_q + STEP;
      end else begin : g_linear
         logic unused_eor;
         assign unused_eor = accept & eor_in;
         assign nxt_ptr    = cur_q + STEP;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         cur_q  <= '0;
      end else if (load_en) begin
         base_q <= load_addr;
         cur_q  <= load_addr;
      end else if (advance) begin
         cur_q  <= nxt_ptr;
      end
   end

   assign cur_ptr  = cur_q;
   assign base_ptr = base_q;

endmodule

// File: rtl/rxd_sticky_flag.sv
module rxd_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   flag_q <= 1'b0;
      else if (set) flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
   end

   assign flag = flag_q;

endmodule

// File: rtl/rxd_run_fsm.sv
module rxd_run_fsm
   import rxd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_en,
   input  logic       frame_avail,
   input  logic       frame_done,
   input  logic       rsp_valid,
   input  logic       desc_own,
   output logic       desc_rd,
   output logic       desc_wb,
   output logic       xfer_active,
   output logic       accept,
   output logic       set_unavail,
   output logic       advance,
   output logic       is_stopped,
   output logic [1:0] run_state
);

   fsm_t st_q, st_nxt;
   logic frame_q;
   logic frame_rise;

   assign frame_rise = frame_avail & ~frame_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= F_STOP;
         frame_q <= 1'b0;
      end else begin
         st_q    <= st_nxt;
         frame_q <= frame_avail;
      end
   end

   always_comb begin
      st_nxt = st_q;
      case (st_q)
         F_STOP:  if (run_en) st_nxt = F_FETCH;
         F_FETCH: st_nxt = F_RSP;
         F_RSP: begin
            if (rsp_valid) st_nxt = desc_own ? F_IDLE : F_SUSP;
         end
         F_IDLE: begin
            if (!run_en)          st_nxt = F_STOP;
            else if (frame_avail) st_nxt = F_XFER;
         end
         F_XFER:  if (frame_done) st_nxt = F_WB;
         F_WB:    st_nxt = run_en ? F_FETCH : F_STOP;
         F_SUSP: begin
            if (!run_en)         st_nxt = F_STOP;
            else if (frame_rise) st_nxt = F_FETCH;
         end
         default: st_nxt = F_STOP;
      endcase
   end

   assign desc_rd     = (st_q == F_FETCH);
   assign desc_wb     = (st_q == F_WB);
   assign xfer_active = (st_q == F_XFER);
   assign advance     = (st_q == F_WB);
   assign accept      = (st_q == F_RSP) && rsp_valid && desc_own;
   assign set_unavail = (st_q == F_RSP) && rsp_valid && !desc_own;
   assign is_stopped  = (st_q == F_STOP);
   assign run_state   = fsm_to_run_state(st_q);

endmodule

// File: rtl/rxdesc_run_ctrl.sv
module rxdesc_run_ctrl #(
   parameter int ADDR_W     = 16,
   parameter int DESC_BYTES = 16,
   parameter int RD_LAT     = 1,
   parameter bit USE_EOR    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              base_wr,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              frame_avail,
   input  logic              frame_done,
   output logic              desc_rd,
   output logic [ADDR_W-1:0] desc_addr,
   input  logic              desc_own,
   input  logic              desc_eor,
   output logic              desc_wb,
   output logic              xfer_active,
   output logic [ADDR_W-1:0] cur_ptr,
   output logic [1:0]        run_state,
   output logic              buf_unavail,
   input  logic              buf_unavail_clr
);

   localparam int STEP_LOG2 = $clog2(DESC_BYTES);

   generate
      if ((DESC_BYTES < 4) || ((DESC_BYTES & (DESC_BYTES - 1)) != 0)) begin : g_bad_step
         $error("DESC_BYTES must be a power of two of at least 4");
      end
      if (ADDR_W <= STEP_LOG2 + 1) begin : g_bad_width
         $error("ADDR_W too narrow for DESC_BYTES");
      end
      if ((RD_LAT < 1) || (RD_LAT > 4)) begin : g_bad_lat
         $error("RD_LAT must lie in 1..4");
      end
   endgenerate

   logic              rsp_valid;
   logic              accept;
   logic              set_unavail;
   logic              advance;
   logic              is_stopped;
   logic [ADDR_W-1:0] base_ptr;
   logic [ADDR_W-1:0] ptr_w;
   logic              unused_base;

   rxd_run_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_en      (run_en),
      .frame_avail (frame_avail),
      .frame_done  (frame_done),
      .rsp_valid   (rsp_valid),
      .desc_own    (desc_own),
      .desc_rd     (desc_rd),
      .desc_wb     (desc_wb),
      .xfer_active (xfer_active),
      .accept      (accept),
      .set_unavail (set_unavail),
      .advance     (advance),
      .is_stopped  (is_stopped),
      .run_state   (run_state)
   );

   rxd_read_tracker #(.RD_LAT(RD_LAT)) u_rd_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (desc_rd),
      .rsp_valid (rsp_valid)
   );

   rxd_ptr_unit #(
      .ADDR_W     (ADDR_W),
      .DESC_BYTES (DESC_BYTES),
      .USE_EOR    (USE_EOR)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (base_wr & is_stopped),
      .load_addr (base_addr),
      .accept    (accept),
      .eor_in    (desc_eor),
      .advance   (advance),
      .cur_ptr   (ptr_w),
      .base_ptr  (base_ptr)
   );

   rxd_sticky_flag u_unavail (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_unavail),
      .clr   (buf_unavail_clr),
      .flag  (buf_unavail)
   );

   assign unused_base = ^base_ptr;
   assign cur_ptr     = ptr_w;
   assign desc_addr   = ptr_w;

endmodule

// File: rtl/rxdesc_run_ctrl_chk.sv
module rxdesc_run_ctrl_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              base_wr,
   input logic              frame_avail,
   input logic              frame_done,
   input logic              desc_rd,
   input logic              desc_wb,
   input logic              xfer_active,
   input logic [ADDR_W-1:0] cur_ptr,
   input logic [1:0]        run_state,
   input logic              buf_unavail,
   input logic              buf_unavail_clr
);

   AST_RD_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      desc_rd |-> (run_state == 2'd1)); // R1

   AST_SUSP_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (run_state != 2'd2) ##1 (run_state == 2'd2) |-> buf_unavail); // R3

   AST_DONE_GIVES_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_active && frame_done) |=> desc_wb); // R4

   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({desc_rd, desc_wb, xfer_active})); // R4

   AST_XFER_DEFERS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_active && !frame_done) |=> (run_state == 2'd1)); // R5

   AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (run_state == 2'd0) |-> (!desc_rd && !desc_wb && !xfer_active)); // R8

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_unavail && !buf_unavail_clr) |=> buf_unavail); // R9

   AST_BASE_IGNORED_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
      (base_wr && run_state == 2'd2) |=> $stable(cur_ptr)); // R10

   AST_SUSP_NO_SPONTANEOUS_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_state == 2'd2 && !frame_avail) |=> !desc_rd); // R11

endmodule

bind rxdesc_run_ctrl rxdesc_run_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .base_wr         (base_wr),
   .frame_avail     (frame_avail),
   .frame_done      (frame_done),
   .desc_rd         (desc_rd),
   .desc_wb         (desc_wb),
   .xfer_active     (xfer_active),
   .cur_ptr         (cur_ptr),
   .run_state       (run_state),
   .buf_unavail     (buf_unavail),
   .buf_unavail_clr (buf_unavail_clr)
);

// File: tb/rxdesc_run_ctrl_bench.sv
module rxdesc_run_ctrl_bench;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_en = 1'b0;
   logic          base_wr = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic          frame_avail = 1'b0;
   logic          frame_done = 1'b0;
   logic          desc_rd;
   logic [AW-1:0] desc_addr;
   logic          desc_own;
   logic          desc_eor;
   logic          desc_wb;
   logic          xfer_active;
   logic [AW-1:0] cur_ptr;
   logic [1:0]    run_state;
   logic          buf_unavail;
   logic          buf_unavail_clr = 1'b0;

   always #2.5 clk = ~clk;

   rxdesc_run_ctrl #(.ADDR_W(AW), .DESC_BYTES(16), .RD_LAT(1), .USE_EOR(1'b1)) u_rxdesc_run_ctrl (
      .clk (clk), .rst_n (rst_n), .run_en (run_en), .base_wr (base_wr),
      .base_addr (base_addr), .frame_avail (frame_avail), .frame_done (frame_done),
      .desc_rd (desc_rd), .desc_addr (desc_addr), .desc_own (desc_own),
      .desc_eor (desc_eor), .desc_wb (desc_wb), .xfer_active (xfer_active),
      .cur_ptr (cur_ptr), .run_state (run_state), .buf_unavail (buf_unavail),
      .buf_unavail_clr (buf_unavail_clr)
   );

   // Descriptor memory model: four entries, last one flagged end-of-ring.
   logic [3:0] mem_own;
   logic       give_req = 1'b0;
   logic [1:0] give_idx = '0;
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_own  <= 4'b1111;
         desc_own <= 1'b0;
         desc_eor <= 1'b0;
      end else begin
         if (desc_rd) begin
            desc_own <= mem_own[desc_addr[5:4]];
            desc_eor <= (desc_addr[5:4] == 2'd3);
         end
         if (desc_wb)  mem_own[desc_addr[5:4]] <= 1'b0;
         if (give_req) mem_own[give_idx] <= 1'b1;
      end
   end

   // Scoreboard
   logic [AW-1:0] exp_q[$];
   logic [AW-1:0] last_rd = '0;
   int sb_cmp = 0;
   int sb_err = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (desc_rd) last_rd = desc_addr;
         if (desc_wb) begin
            sb_cmp++;
            if (exp_q.size() == 0) begin
               sb_err++;
               $display("FAIL R4: unexpected write-back at %h, expected none", desc_addr);
            end else begin
               logic [AW-1:0] e;
               e = exp_q.pop_front();
               if (desc_addr !== e) begin
                  sb_err++;
                  $display("FAIL R4: write-back at %h, expected %h", desc_addr, e);
               end
            end
         end
      end
   end

   int  n_chk = 0;
   int  n_err = 0;
   bit  done_flag = 1'b0;

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                  n_chk + sb_cmp, n_err + sb_err);
         $finish;
      end
   endtask

   task automatic give(logic [1:0] idx);
      give_req = 1'b1;
      give_idx = idx;
      tick();
      give_req = 1'b0;
   endtask

   task automatic write_base(logic [AW-1:0] a);
      base_addr = a;
      base_wr   = 1'b1;
      tick();
      base_wr   = 1'b0;
      tick();
   endtask

   task automatic wait_xfer(string req);
      int n = 0;
      while (!xfer_active && n < 40) begin
         tick();
         n++;
      end
      check(req, {31'd0, xfer_active}, 32'd1);
   endtask

   // Driver: one frame through the data path, expected write-back queued.
   task automatic do_frame(logic [AW-1:0] exp_addr, bit stop_mid);
      exp_q.push_back(exp_addr);
      frame_avail = 1'b1;
      wait_xfer("R4");
      frame_avail = 1'b0;
      if (stop_mid) begin
         run_en = 1'b0;
         repeat (3) tick();
         check("R5", {30'd0, run_state}, 32'd1);
      end
      frame_done = 1'b1;
      tick();
      frame_done = 1'b0;
      repeat (3) tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) tick();
      rst_n = 1'b1;
      tick();
      check("R8", {30'd0, run_state}, 32'd0);
      check("R8", {16'd0, cur_ptr}, 32'd0);
      check("R8", {31'd0, buf_unavail}, 32'd0);
      check("R8", {29'd0, desc_rd, desc_wb, xfer_active}, 32'd0);

      write_base(16'h0100);
      check("R2", {16'd0, cur_ptr}, 32'h100);

      run_en = 1'b1;
      repeat (3) tick();
      check("R1", {30'd0, run_state}, 32'd1);
      check("R1", {16'd0, last_rd}, 32'h100);

      // Full lap: step by 16, wrap on end-of-ring
      do_frame(16'h0100, 1'b0);
      check("R4", {16'd0, cur_ptr}, 32'h110);
      do_frame(16'h0110, 1'b0);
      do_frame(16'h0120, 1'b0);
      do_frame(16'h0130, 1'b0);
      check("R4", {16'd0, cur_ptr}, 32'h100);

      // Ring now host-owned: suspend
      repeat (2) tick();
      check("R3", {30'd0, run_state}, 32'd2);
      check("R3", {31'd0, buf_unavail}, 32'd1);

      // No reads while suspended without a new frame
      begin
         int rds = 0;
         for (int i = 0; i < 10; i++) begin
            tick();
            if (desc_rd) rds++;
         end
         check("R11", rds, 32'd0);
      end

      write_base(16'h0200);
      check("R10", {16'd0, cur_ptr}, 32'h100);
      check("R9", {31'd0, buf_unavail}, 32'd1);

      buf_unavail_clr = 1'b1;
      tick();
      buf_unavail_clr = 1'b0;
      tick();
      check("R9", {31'd0, buf_unavail}, 32'd0);

      // Re-poll on new frame after ownership is returned
      give(2'd0);
      tick();
      check("R11", {30'd0, run_state}, 32'd2);
      do_frame(16'h0100, 1'b0);
      check("R7", {16'd0, cur_ptr}, 32'h110);
      check("R10", {16'd0, cur_ptr}, 32'h110);
      repeat (2) tick();
      check("R3", {30'd0, run_state}, 32'd2);

      // Stop while suspended
      run_en = 1'b0;
      repeat (2) tick();
      check("R6", {30'd0, run_state}, 32'd0);
      check("R6", {16'd0, cur_ptr}, 32'h110);

      give(2'd1);
      give(2'd2);
      run_en = 1'b1;
      repeat (4) tick();
      check("R2", {16'd0, last_rd}, 32'h110);
      check("R7", {30'd0, run_state}, 32'd1);

      // Stop requested in the middle of a transfer
      do_frame(16'h0110, 1'b1);
      check("R5", {30'd0, run_state}, 32'd0);
      check("R5", {16'd0, cur_ptr}, 32'h120);

      run_en = 1'b1;
      repeat (4) tick();
      check("R2", {16'd0, last_rd}, 32'h120);
      check("R1", {30'd0, run_state}, 32'd1);

      // Stop while idle in Running
      run_en = 1'b0;
      repeat (2) tick();
      check("R6", {30'd0, run_state}, 32'd0);
      check("R6", {16'd0, cur_ptr}, 32'h120);

      write_base(16'h0100);
      check("R2", {16'd0, cur_ptr}, 32'h100);

      check("R4", exp_q.size(), 32'd0);
      tick();
      finish_run();
   end

endmodule